// File: doc/BRIEF.md
# Core-to-Monitor Cluster Crossbar

This block sits between a small group of processor cores and a larger pool of runtime integrity monitors. Every core emits a short instruction hash with a valid strobe each time it retires an instruction. The crossbar carries that stream to whichever monitor is currently bound to the core. It also carries the monitor's reset/recover pulse back to that same core, so any core can be served by any free monitor.

Bindings are changed at runtime through a narrow write port. A write names a core and a monitor index. A write that would give one monitor to two cores is refused and raises a flag. An accepted write is parked until its core reports that it is between packets, so one packet's hash stream never ends up split across two monitors.

Hash and valid steering toward the monitors is combinational from the binding state. So is reset/recover steering back to the cores.

Top module: `mon_cluster_xbar`

## Requirements
- R1: After reset every core is unassigned and every monitor unbound: all `mon_valid`, `mon_hash` and `core_rr` bits are 0, and `cfg_conflict` is 0.
- R2: When core c is bound to monitor m (select value m, 0..N_MONS-1, 3 bits wide by default), `mon_hash` slice m equals `core_hash` slice c and `mon_valid[m]` equals `core_valid[c]` in the same cycle.
- R3: A monitor bound to no core sees `mon_valid` 0 and a zero hash, whatever the cores drive.
- R4: `core_rr[c]` equals `mon_rr[m]` of the monitor bound to core c. It is 0 while core c is unassigned, and the recover output of an unbound monitor reaches no core.
- R5: A select value of N_MONS or above (6 or 7 by default) unassigns the core. Its former monitor becomes unbound and may then be given to another core.
- R6: A write whose monitor is already held by a different core is rejected. The binding does not change, and `cfg_conflict` reads 1 from the next cycle.
- R7: An accepted write sets `cfg_conflict` to 0 from the next cycle.
- R8: An accepted write is stored as pending on the clock edge where `cfg_we` is sampled. It becomes the live binding on the first later edge at which that core's `core_idle` bit is 1, and the old binding holds until then.
- R9: A second accepted write to a core whose earlier write is still pending replaces the earlier one.
- R10: The conflict test also counts monitors named by other cores' pending writes, not only their live bindings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_hash | input | N_CORES*HASH_W | Per-core instruction hash, core c in slice c |
| core_valid | input | N_CORES | Per-core hash strobe |
| core_idle | input | N_CORES | Core is between packets; a pending binding may apply |
| mon_rr | input | N_MONS | Per-monitor reset/recover request |
| cfg_we | input | 1 | Binding write strobe |
| cfg_core | input | PSEL_W | Core addressed by the write |
| cfg_msel | input | MSEL_W | Monitor index, or N_MONS and above for unassign |
| mon_hash | output | N_MONS*HASH_W | Hash delivered to each monitor |
| mon_valid | output | N_MONS | Strobe delivered to each monitor |
| core_rr | output | N_CORES | Reset/recover delivered to each core |
| cfg_conflict | output | 1 | Last write was rejected for a shared monitor |

## Verification
The hardest case to reach is a conflict that exists only in pending state. A core holds a parked write while it stays busy, and a second core then asks for the same monitor before the first write has applied. The stimulus reaches this case by holding one core's idle bit low across several writes, then aiming another core at the parked target. The same held-busy window is reused to show that a later write overrides a parked one, and that the live binding does not move until the idle bit rises.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
   // width of a monitor select that also carries an "unassigned" code
   function automatic int msel_width(input int n_mons);
      return $clog2(n_mons + 1);
   endfunction
   // width of a core index, at least one bit
   function automatic int psel_width(input int n_cores);
      return (n_cores > 1) ? $clog2(n_cores) : 1;
   endfunction
endpackage

// File: rtl/mcx_bind.sv
module mcx_bind
   import mcx_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int N_MONS  = 6,
   localparam int MSEL_W = msel_width(N_MONS),
   localparam int PSEL_W = psel_width(N_CORES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_CORES-1:0]                core_idle,
   input  logic                              cfg_we,
   input  logic [PSEL_W-1:0]                 cfg_core,
   input  logic [MSEL_W-1:0]                 cfg_msel,
   output logic [N_CORES-1:0][MSEL_W-1:0]    act_sel,
   output logic [N_MONS-1:0]                 mon_bound,
   output logic [N_MONS-1:0][PSEL_W-1:0]     mon_psel,
   output logic                              cfg_conflict
);
   localparam logic [MSEL_W-1:0] SEL_NONE = MSEL_W'(N_MONS);

   logic [N_CORES-1:0]               pend_v;
   logic [N_CORES-1:0][MSEL_W-1:0]   pend_sel;
   logic [N_CORES-1:0]               apply;
   logic                             core_ok;
   logic                             conflict_hit;
   logic                             wr_ok;
   logic [N_MONS-1:0]                bound_nxt;
   logic [N_MONS-1:0][PSEL_W-1:0]    psel_nxt;

   assign core_ok = (int'(cfg_core) < N_CORES);
   assign apply   = pend_v & core_idle;

   // a monitor is taken if another core holds it live or has it parked
   always_comb begin
      conflict_hit = 1'b0;
      for (int k = 0; k < N_CORES; k++) begin
         if (PSEL_W'(k) != cfg_core && cfg_msel < SEL_NONE) begin
            if (act_sel[k] == cfg_msel) conflict_hit = 1'b1;
            if (pend_v[k] && pend_sel[k] == cfg_msel) conflict_hit = 1'b1;
         end
      end
   end

   assign wr_ok = cfg_we && core_ok && !conflict_hit;

   // reverse map: release old monitors first, then claim new ones
   always_comb begin
      bound_nxt = mon_bound;
      psel_nxt  = mon_psel;
      for (int m = 0; m < N_MONS; m++) begin
         for (int c = 0; c < N_CORES; c++) begin
            if (apply[c] && act_sel[c] == MSEL_W'(m)) bound_nxt[m] = 1'b0;
         end
         for (int c = 0; c < N_CORES; c++) begin
            if (apply[c] && pend_sel[c] == MSEL_W'(m)) begin
               bound_nxt[m] = 1'b1;
               psel_nxt[m]  = PSEL_W'(c);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < N_CORES; c++) begin
            act_sel[c]  <= SEL_NONE;
            pend_sel[c] <= SEL_NONE;
         end
         pend_v       <= '0;
         mon_bound    <= '0;
         mon_psel     <= '0;
         cfg_conflict <= 1'b0;
      end else begin
         for (int c = 0; c < N_CORES; c++) begin
            if (apply[c]) begin
               act_sel[c] <= pend_sel[c];
               pend_v[c]  <= 1'b0;
            end
         end
         if (wr_ok) begin
            pend_sel[cfg_core] <= cfg_msel;
            pend_v[cfg_core]   <= 1'b1;
         end
         mon_bound <= bound_nxt;
         mon_psel  <= psel_nxt;
         if (cfg_we && core_ok) cfg_conflict <= conflict_hit;
      end
   end

   // R6
   reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && core_ok && conflict_hit) |=> (cfg_conflict && $stable(pend_sel)));

   // R7
   accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !cfg_conflict);

   generate
      for (genvar gc = 0; gc < N_CORES; gc++) begin : g_core_chk
         // R8
         idle_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(act_sel[gc]) |-> $past(core_idle[gc]));
      end
      for (genvar gm = 0; gm < N_MONS; gm++) begin : g_mon_chk
         logic [N_CORES-1:0] owners;
         always_comb begin
            for (int c = 0; c < N_CORES; c++) owners[c] = (act_sel[c] == MSEL_W'(gm));
         end
         // R6
         single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owners) <= 1);
         // R4
         reverse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mon_bound[gm] |-> (act_sel[mon_psel[gm]] == MSEL_W'(gm)));
      end
   endgenerate
endmodule

// File: rtl/mcx_fwd.sv
module mcx_fwd
   import mcx_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int N_MONS  = 6,
   parameter int HASH_W  = 4,
   localparam int PSEL_W = psel_width(N_CORES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_CORES-1:0][HASH_W-1:0]    core_hash,
   input  logic [N_CORES-1:0]                core_valid,
   input  logic [N_MONS-1:0]                 mon_bound,
   input  logic [N_MONS-1:0][PSEL_W-1:0]     mon_psel,
   output logic [N_MONS-1:0][HASH_W-1:0]     mon_hash,
   output logic [N_MONS-1:0]                 mon_valid
);
   generate
      for (genvar gm = 0; gm < N_MONS; gm++) begin : g_mon
         always_comb begin
            if (mon_bound[gm]) begin
               mon_hash[gm]  = core_hash[mon_psel[gm]];
               mon_valid[gm] = core_valid[mon_psel[gm]];
            end else begin
               mon_hash[gm]  = '0;
               mon_valid[gm] = 1'b0;
            end
         end
         // R3
         unbound_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mon_bound[gm] |-> (!mon_valid[gm] && mon_hash[gm] == '0));
      end
   endgenerate
endmodule

// File: rtl/mcx_ret.sv
module mcx_ret
   import mcx_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int N_MONS  = 6,
   localparam int MSEL_W = msel_width(N_MONS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_CORES-1:0][MSEL_W-1:0]    act_sel,
   input  logic [N_MONS-1:0]                 mon_rr,
   output logic [N_CORES-1:0]                core_rr
);
   generate
      for (genvar gc = 0; gc < N_CORES; gc++) begin : g_core
         always_comb begin
            core_rr[gc] = 1'b0;
            for (int m = 0; m < N_MONS; m++) begin
               if (act_sel[gc] == MSEL_W'(m)) core_rr[gc] = mon_rr[m];
            end
         end
         // R4
         unassigned_no_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_sel[gc] >= MSEL_W'(N_MONS)) |-> !core_rr[gc]);
      end
   endgenerate
endmodule

// File: rtl/mon_cluster_xbar.sv
module mon_cluster_xbar
   import mcx_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int N_MONS  = 6,
   parameter int HASH_W  = 4,
   localparam int MSEL_W = msel_width(N_MONS),
   localparam int PSEL_W = psel_width(N_CORES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_CORES*HASH_W-1:0]    core_hash,
   input  logic [N_CORES-1:0]           core_valid,
   input  logic [N_CORES-1:0]           core_idle,
   input  logic [N_MONS-1:0]            mon_rr,
   input  logic                         cfg_we,
   input  logic [PSEL_W-1:0]            cfg_core,
   input  logic [MSEL_W-1:0]            cfg_msel,
   output logic [N_MONS*HASH_W-1:0]     mon_hash,
   output logic [N_MONS-1:0]            mon_valid,
   output logic [N_CORES-1:0]           core_rr,
   output logic                         cfg_conflict
);
   generate
      if (N_CORES < 2)       begin : g_bad_cores $error("N_CORES must be at least 2"); end
      if (N_MONS < N_CORES)  begin : g_bad_mons  $error("N_MONS must not be below N_CORES"); end
      if (HASH_W < 1)        begin : g_bad_hash  $error("HASH_W must be positive"); end
   endgenerate

   logic [N_CORES-1:0][HASH_W-1:0]   hash_arr;
   logic [N_MONS-1:0][HASH_W-1:0]    mhash_arr;
   logic [N_CORES-1:0][MSEL_W-1:0]   act_sel;
   logic [N_MONS-1:0]                mon_bound;
   logic [N_MONS-1:0][PSEL_W-1:0]    mon_psel;

   assign hash_arr = core_hash;
   assign mon_hash = mhash_arr;

   mcx_bind #(.N_CORES(N_CORES), .N_MONS(N_MONS)) i_bind (
      .clk(clk), .rst_n(rst_n), .core_idle(core_idle),
      .cfg_we(cfg_we), .cfg_core(cfg_core), .cfg_msel(cfg_msel),
      .act_sel(act_sel), .mon_bound(mon_bound), .mon_psel(mon_psel),
      .cfg_conflict(cfg_conflict)
   );

   mcx_fwd #(.N_CORES(N_CORES), .N_MONS(N_MONS), .HASH_W(HASH_W)) i_fwd (
      .clk(clk), .rst_n(rst_n), .core_hash(hash_arr), .core_valid(core_valid),
      .mon_bound(mon_bound), .mon_psel(mon_psel),
      .mon_hash(mhash_arr), .mon_valid(mon_valid)
   );

   mcx_ret #(.N_CORES(N_CORES), .N_MONS(N_MONS)) i_ret (
      .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .mon_rr(mon_rr),
      .core_rr(core_rr)
   );
endmodule

// File: tb/test_mon_cluster_xbar.sv
module test_mon_cluster_xbar;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NM = 6;
   localparam int HW = 4;

   typedef struct {
      string            tag;
      logic [NM*HW-1:0] mh;
      logic [NM-1:0]    mv;
      logic [NC-1:0]    rr;
      logic             fl;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC*HW-1:0] core_hash = '0;
   logic [NC-1:0]    core_valid = '0;
   logic [NC-1:0]    core_idle = '1;
   logic [NM-1:0]    mon_rr = '0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_core = '0;
   logic [2:0]       cfg_msel = '0;
   logic [NM*HW-1:0] mon_hash;
   logic [NM-1:0]    mon_valid;
   logic [NC-1:0]    core_rr;
   logic             cfg_conflict;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   logic [31:0] lfsr = 32'h1D5A_93C7;
   exp_t q[$];

   // bench model of the binding state
   int   m_act[NC];
   logic m_pv[NC];
   int   m_ps[NC];
   logic m_fl;

   always #(CLK_PERIOD/2) clk = ~clk;

   mon_cluster_xbar i_mon_cluster_xbar (
      .clk(clk), .rst_n(rst_n), .core_hash(core_hash), .core_valid(core_valid),
      .core_idle(core_idle), .mon_rr(mon_rr), .cfg_we(cfg_we), .cfg_core(cfg_core),
      .cfg_msel(cfg_msel), .mon_hash(mon_hash), .mon_valid(mon_valid),
      .core_rr(core_rr), .cfg_conflict(cfg_conflict)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below 5000", cyc);
         finish_run();
      end
   end

   // monitor: pop expected items and compare away from the clock edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_checks++;
         if (mon_hash !== e.mh || mon_valid !== e.mv || core_rr !== e.rr || cfg_conflict !== e.fl) begin
            n_fail++;
            $display("FAIL %s: actual hash=%h valid=%b rr=%b flag=%b expected hash=%h valid=%b rr=%b flag=%b",
                     e.tag, mon_hash, mon_valid, core_rr, cfg_conflict, e.mh, e.mv, e.rr, e.fl);
         end
      end
   end

   // mirror of one clock edge using the inputs in force at that edge
   task automatic model_edge();
      logic hit = 1'b0;
      int wc = int'(cfg_core);
      int ws = int'(cfg_msel);
      if (cfg_we) begin
         for (int k = 0; k < NC; k++) begin
            if (k != wc && ws < NM && (m_act[k] == ws || (m_pv[k] && m_ps[k] == ws))) hit = 1'b1;
         end
      end
      for (int c = 0; c < NC; c++) begin
         if (m_pv[c] && core_idle[c]) begin
            m_act[c] = m_ps[c];
            m_pv[c]  = 1'b0;
         end
      end
      if (cfg_we) begin
         if (hit) m_fl = 1'b1;
         else begin
            m_ps[wc] = ws;
            m_pv[wc] = 1'b1;
            m_fl     = 1'b0;
         end
      end
   endtask

   task automatic push_expect(input string tag);
      exp_t e;
      e.tag = tag;
      e.mh = '0;
      e.mv = '0;
      e.rr = '0;
      e.fl = m_fl;
      for (int c = 0; c < NC; c++) begin
         if (m_act[c] < NM) begin
            e.mh[m_act[c]*HW +: HW] = core_hash[c*HW +: HW];
            e.mv[m_act[c]] = core_valid[c];
            e.rr[c] = mon_rr[m_act[c]];
         end
      end
      q.push_back(e);
   endtask

   // driver: one cycle, new inputs after the edge, expectation for the new state
   task automatic drive(input string tag, input logic we, input int core, input int msel,
                        input logic [NC-1:0] idle);
      @(posedge clk);
      model_edge();
      #1;
      cfg_we    = we;
      cfg_core  = 2'(core);
      cfg_msel  = 3'(msel);
      core_idle = idle;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      core_hash  = lfsr[15:0];
      core_valid = lfsr[19:16] | 4'b0101;
      mon_rr     = lfsr[25:20];
      push_expect(tag);
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin
         m_act[c] = 7;
         m_pv[c]  = 1'b0;
         m_ps[c]  = 7;
      end
      m_fl = 1'b0;
      core_hash = 16'hBEEF;
      core_valid = '1;
      mon_rr = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push_expect("R1 reset state");

      drive("R1 idle after reset", 0, 0, 0, 4'b1111);
      drive("R2 write core0 to mon2", 1, 0, 2, 4'b1111);
      drive("R8 parked, not live yet", 0, 0, 0, 4'b1111);
      drive("R2 core0 on mon2", 0, 0, 0, 4'b1111);
      drive("R2 core0 on mon2 traffic", 0, 0, 0, 4'b1111);

      drive("R8 write busy core1 to mon5", 1, 1, 5, 4'b1101);
      drive("R8 busy hold", 0, 0, 0, 4'b1101);
      drive("R8 busy hold", 0, 0, 0, 4'b1101);
      drive("R8 busy hold", 0, 0, 0, 4'b1101);
      drive("R8 idle rises", 0, 0, 0, 4'b1111);
      drive("R4 core1 on mon5", 0, 0, 0, 4'b1111);
      drive("R4 recover routing", 0, 0, 0, 4'b1111);

      drive("R6 core2 asks for mon2", 1, 2, 2, 4'b1111);
      drive("R6 flag raised, no bind", 0, 0, 0, 4'b1111);
      drive("R3 unbound monitors quiet", 0, 0, 0, 4'b1111);

      drive("R7 accepted core2 to mon0 while busy", 1, 2, 0, 4'b1011);
      drive("R7 flag cleared", 0, 0, 0, 4'b1011);
      drive("R10 core3 asks for parked mon0", 1, 3, 0, 4'b1011);
      drive("R10 flag raised", 0, 0, 0, 4'b1011);
      drive("R10 core2 applies", 0, 0, 0, 4'b1111);
      drive("R10 core2 on mon0", 0, 0, 0, 4'b1111);

      drive("R5 unassign core0 with code 7", 1, 0, 7, 4'b1111);
      drive("R5 pending unassign", 0, 0, 0, 4'b1111);
      drive("R5 core0 released, mon2 free", 0, 0, 0, 4'b1111);
      drive("R4 unassigned core no recover", 0, 0, 0, 4'b1111);
      drive("R5 code 6 unassigns core1", 1, 1, 6, 4'b1111);
      drive("R5 code 6 pending", 0, 0, 0, 4'b1111);
      drive("R5 core1 released", 0, 0, 0, 4'b1111);

      drive("R9 core3 busy write mon1", 1, 3, 1, 4'b0111);
      drive("R9 override core3 to mon3", 1, 3, 3, 4'b0111);
      drive("R9 busy hold", 0, 0, 0, 4'b0111);
      drive("R9 apply", 0, 0, 0, 4'b1111);
      drive("R9 core3 on mon3, mon1 unbound", 0, 0, 0, 4'b1111);

      drive("R5 freed mon2 reused by core1", 1, 1, 2, 4'b1111);
      drive("R5 reuse pending", 0, 0, 0, 4'b1111);
      drive("R5 core1 on mon2", 0, 0, 0, 4'b1111);
      drive("R6 core0 asks for mon3", 1, 0, 3, 4'b1111);
      drive("R6 rejected flag", 0, 0, 0, 4'b1111);

      for (int i = 0; i < 10; i++) drive("R2 R4 traffic mix", 0, 0, 0, 4'b1111);

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule